// File: doc/BRIEF.md
# Companion I/O Register and GPIO Block

This block is a small 16-bit register-file peripheral that sits on a byte-addressed register port. It holds eleven registers:

- storage for mode, card detect, control, raw interrupt, interrupt mask, interrupt status and a general readback word;
- a power register with a write side effect;
- a fixed ready/status word;
- a direction register and an output level register that together drive 16 general-purpose output lines.

The effective output is the stored level masked by the direction register. It is re-evaluated only when software writes the direction or the level register. On each such evaluation, every output bit whose effective value changed is reported as a one-cycle pulse on a change vector. The new levels appear on the output bus in that same cycle, so a consumer can pair each pulse bit with its new level.

External logic may also set or clear single level bits through a line/level request. Such a request updates the stored level but does not re-evaluate the outputs. The new value becomes visible on the outputs at the next direction or level write. Requests that name a line at or above the GPIO count are dropped.

Reads are combinational on the address. Writes take effect at the clock edge and keep only the low 16 bits of the bus word.

Top module: `companion_io_regs`

## Requirements
- R1: After reset, every stored register reads 0x0000, the status word at offset 0x08 reads 0x0002, gpio_o is 0 and gpio_chg_o is 0.
- R2: Offsets 0x00, 0x04, 0x10, 0x14, 0x18, 0x1C and 0x28 are independent plain registers. A write stores bits 15:0 of wr_data_i, and rd_data_o returns the stored value in the same cycle the address is presented.
- R3: Offset 0x08 always reads 0x0002, and writes to it are ignored.
- R4: A write to offset 0x0C stores the data, with bits 15 and 6 also forced to 1 when data bit 7 is 1 (the stored value is data OR 0x8040).
- R5: Any other offset reads 0x0000, and a write to it changes no register.
- R6: A write to offset 0x20 stores the direction mask (1 = output enabled), which reads back unmodified, and starts an output evaluation.
- R7: A write to offset 0x24 stores the data ANDed with the direction mask held before that write, and starts an output evaluation. Offset 0x24 reads back the stored level.
- R8: gpio_o equals level AND direction as computed at the most recent evaluation, and changes only on an evaluation. In the cycle after an evaluating write, gpio_chg_o has a 1 on each bit whose gpio_o value changed. At all other times gpio_chg_o is 0.
- R9: An external request with ext_line_i below 16 sets or clears that level bit without evaluating the outputs. A request with ext_line_i of 16 or more is ignored.
- R10: When a level-register write and an external request occur in the same cycle, the register write alone determines the stored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for both read and write |
| wr_data_i | input | 32 | Write data; only bits 15:0 are kept |
| rd_data_o | output | 16 | Read data for addr_i (combinational) |
| ext_vld_i | input | 1 | External level-set request |
| ext_line_i | input | 5 | Line index of the external request |
| ext_level_i | input | 1 | Level to place on that line |
| gpio_o | output | 16 | Effective output levels |
| gpio_chg_o | output | 16 | One-cycle change pulses per output line |

## Verification
The hardest situation to reach from the ports is a stored level that differs from what is driven. This happens when an external request changes a level bit without evaluation, or when the direction is narrowed under a level that is still stored. The stimulus first uses external requests to set and clear level bits while gpio_o is held still. It then rewrites the direction with an unchanged value, which forces an evaluation and releases the hidden change as a single pulse. A level write that coincides with an external request, and a level write made under a narrow direction mask, then check that the masking uses the direction held before the write.

// File: rtl/cio_pkg.sv
package cio_pkg;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CDET   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_STAT   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_PWR    = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_CTL    = 8'h10;
  localparam logic [OFS_W-1:0] OFS_IRAW   = 8'h14;
  localparam logic [OFS_W-1:0] OFS_IMSK   = 8'h18;
  localparam logic [OFS_W-1:0] OFS_ISTS   = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_DIR    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_LVL    = 8'h24;
  localparam logic [OFS_W-1:0] OFS_RDBK   = 8'h28;

  localparam int unsigned N_PLAIN = 7;
  localparam logic [OFS_W-1:0] PLAIN_OFS [N_PLAIN] =
    '{OFS_MODE, OFS_CDET, OFS_CTL, OFS_IRAW, OFS_IMSK, OFS_ISTS, OFS_RDBK};

  localparam int unsigned PWR_TRIG_BIT = 7;
  localparam logic [15:0] PWR_SET_MASK = 16'h8040;
  localparam logic [15:0] STAT_VALUE   = 16'h0002;
endpackage

// File: rtl/cio_plain_regs.sv
module cio_plain_regs
  import cio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wd_i,
  output logic [N_PLAIN-1:0][DATA_W-1:0]  q_o
);
  for (genvar i = 0; i < N_PLAIN; i++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(PLAIN_OFS[i]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_o[i] <= '0;
      else if (hit) q_o[i] <= wd_i;
    end
  end
endmodule

// File: rtl/cio_pwr_reg.sv
module cio_pwr_reg
  import cio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] q_o
);
  logic              hit;
  logic [DATA_W-1:0] wd_fx;

  assign hit   = wr_en_i && (addr_i == ADDR_W'(OFS_PWR));
  // trigger bit forces the extra enable bits on
  assign wd_fx = wd_i[PWR_TRIG_BIT] ? (wd_i | DATA_W'(PWR_SET_MASK)) : wd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (hit) q_o <= wd_fx;
  end
endmodule

// File: rtl/cio_gpio_unit.sv
module cio_gpio_unit #(
  parameter int unsigned N_GPIO = 16,
  parameter int unsigned LINE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dir_i,
  input  logic              wr_lvl_i,
  input  logic [N_GPIO-1:0] wd_i,
  input  logic              ext_vld_i,
  input  logic [LINE_W-1:0] ext_line_i,
  input  logic              ext_level_i,
  output logic [N_GPIO-1:0] dir_o,
  output logic [N_GPIO-1:0] lvl_o,
  output logic [N_GPIO-1:0] gpio_o,
  output logic [N_GPIO-1:0] chg_o
);
  logic [N_GPIO-1:0] dir_d, lvl_d, eff_d;
  logic              eval;

  assign dir_d = wr_dir_i ? wd_i : dir_o;
  assign eval  = wr_dir_i | wr_lvl_i;
  assign eff_d = lvl_d & dir_d;

  always_comb begin
    lvl_d = lvl_o;
    if (wr_lvl_i) begin
      lvl_d = wd_i & dir_o;
    end else if (ext_vld_i) begin
      for (int i = 0; i < N_GPIO; i++) begin
        if (ext_line_i == LINE_W'(i)) lvl_d[i] = ext_level_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      lvl_o  <= '0;
      gpio_o <= '0;
      chg_o  <= '0;
    end else begin
      dir_o <= dir_d;
      lvl_o <= lvl_d;
      if (eval) begin
        gpio_o <= eff_d;
        chg_o  <= gpio_o ^ eff_d;
      end else begin
        chg_o  <= '0;
      end
    end
  end
endmodule

// File: rtl/cio_read_mux.sv
module cio_read_mux
  import cio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_GPIO = 16
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [N_PLAIN-1:0][DATA_W-1:0] plain_i,
  input  logic [DATA_W-1:0]              pwr_i,
  input  logic [N_GPIO-1:0]              dir_i,
  input  logic [N_GPIO-1:0]              lvl_i,
  output logic [DATA_W-1:0]              rd_o
);
  always_comb begin
    rd_o = '0;
    for (int i = 0; i < N_PLAIN; i++) begin
      if (addr_i == ADDR_W'(PLAIN_OFS[i])) rd_o = plain_i[i];
    end
    if (addr_i == ADDR_W'(OFS_STAT)) rd_o = DATA_W'(STAT_VALUE);
    if (addr_i == ADDR_W'(OFS_PWR))  rd_o = pwr_i;
    if (addr_i == ADDR_W'(OFS_DIR))  rd_o = DATA_W'(dir_i);
    if (addr_i == ADDR_W'(OFS_LVL))  rd_o = DATA_W'(lvl_i);
  end
endmodule

// File: rtl/companion_io_regs.sv
module companion_io_regs
  import cio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_GPIO = 16,
  localparam int unsigned LINE_W = $clog2(N_GPIO) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ext_vld_i,
  input  logic [LINE_W-1:0] ext_line_i,
  input  logic              ext_level_i,
  output logic [N_GPIO-1:0] gpio_o,
  output logic [N_GPIO-1:0] gpio_chg_o
);
  logic [DATA_W-1:0]              wd;
  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]              pwr_q;
  logic [N_GPIO-1:0]              dir_q, lvl_q;
  logic                           wr_dir, wr_lvl;

  assign wd     = wr_data_i[DATA_W-1:0];
  assign wr_dir = wr_en_i && (addr_i == ADDR_W'(OFS_DIR));
  assign wr_lvl = wr_en_i && (addr_i == ADDR_W'(OFS_LVL));

  cio_plain_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_plain (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wd_i(wd), .q_o(plain_q)
  );

  cio_pwr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wd_i(wd), .q_o(pwr_q)
  );

  cio_gpio_unit #(.N_GPIO(N_GPIO), .LINE_W(LINE_W)) u_gpio (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_dir_i(wr_dir), .wr_lvl_i(wr_lvl),
    .wd_i(wd[N_GPIO-1:0]), .ext_vld_i(ext_vld_i), .ext_line_i(ext_line_i),
    .ext_level_i(ext_level_i), .dir_o(dir_q), .lvl_o(lvl_q),
    .gpio_o(gpio_o), .chg_o(gpio_chg_o)
  );

  cio_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_GPIO(N_GPIO)) u_rd (
    .addr_i(addr_i), .plain_i(plain_q), .pwr_i(pwr_q), .dir_i(dir_q),
    .lvl_i(lvl_q), .rd_o(rd_data_o)
  );
endmodule

// File: rtl/cio_chk.sv
module cio_chk
  import cio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_GPIO = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [N_GPIO-1:0] gpio_o,
  input logic [N_GPIO-1:0] gpio_chg_o,
  input logic [N_GPIO-1:0] dir_i,
  input logic [DATA_W-1:0] pwr_i
);
  logic eval_wr;
  assign eval_wr = wr_en_i &&
                   (addr_i == ADDR_W'(OFS_DIR) || addr_i == ADDR_W'(OFS_LVL));

  // R3
  stat_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_STAT)) |-> (rd_data_o == DATA_W'(STAT_VALUE)));

  // R4
  pwr_side_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_PWR) && wr_data_i[PWR_TRIG_BIT])
    |=> ((pwr_i & DATA_W'(PWR_SET_MASK)) == DATA_W'(PWR_SET_MASK)));

  // R8
  chg_needs_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_chg_o != '0) |-> $past(eval_wr));

  // R8
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_wr |=> $stable(gpio_o));

  // R8
  chg_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_wr |=> (gpio_chg_o == (gpio_o ^ $past(gpio_o))));

  // R6
  out_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gpio_o & ~dir_i) == '0));
endmodule

bind companion_io_regs cio_chk #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .N_GPIO(N_GPIO)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .gpio_o(gpio_o),
  .gpio_chg_o(gpio_chg_o), .dir_i(dir_q), .pwr_i(pwr_q)
);

// File: tb/companion_io_regs_tb.sv
module companion_io_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        ext_vld_i = 1'b0;
  logic [4:0]  ext_line_i = '0;
  logic        ext_level_i = 1'b0;
  logic [15:0] gpio_o, gpio_chg_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] cap_chg, cap_gpio;

  always #10 clk_i = ~clk_i;

  companion_io_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ext_vld_i(ext_vld_i),
    .ext_line_i(ext_line_i), .ext_level_i(ext_level_i), .gpio_o(gpio_o),
    .gpio_chg_o(gpio_chg_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    cap_chg = gpio_chg_o; cap_gpio = gpio_o;
  endtask

  task automatic ext(input logic [4:0] line, input logic lvl);
    @(negedge clk_i);
    ext_vld_i = 1'b1; ext_line_i = line; ext_level_i = lvl;
    @(negedge clk_i);
    ext_vld_i = 1'b0;
    cap_chg = gpio_chg_o; cap_gpio = gpio_o;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #2 chk(req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    logic [7:0] ofs [11] = '{8'h00,8'h04,8'h0C,8'h10,8'h14,8'h18,8'h1C,8'h20,8'h24,8'h28,8'h08};
    for (int i = 0; i < 10; i++) rd_chk("R1 reset reg", ofs[i], 16'h0000);
    rd_chk("R1 reset status", ofs[10], 16'h0002);
    chk("R1 reset gpio", gpio_o, 16'h0000);
    chk("R1 reset chg", gpio_chg_o, 16'h0000);
  endtask

  task automatic t_plain;
    logic [7:0] ofs [7] = '{8'h00,8'h04,8'h10,8'h14,8'h18,8'h1C,8'h28};
    for (int i = 0; i < 7; i++) wr(ofs[i], {16'hDEAD, ofs[i], 8'h5A});
    for (int i = 0; i < 7; i++) rd_chk("R2 plain readback", ofs[i], {ofs[i], 8'h5A});
  endtask

  task automatic t_status;
    wr(8'h08, 32'h0000_FFFF);
    rd_chk("R3 status write ignored", 8'h08, 16'h0002);
  endtask

  task automatic t_power;
    wr(8'h0C, 32'h0000_0080); rd_chk("R4 pwr trig", 8'h0C, 16'h80C0);
    wr(8'h0C, 32'h0000_0100); rd_chk("R4 pwr plain", 8'h0C, 16'h0100);
    wr(8'h0C, 32'hFFFF_00FF); rd_chk("R4 pwr trig trunc", 8'h0C, 16'h80FF);
  endtask

  task automatic t_undef;
    wr(8'h2C, 32'h0000_FFFF);
    wr(8'h01, 32'h0000_FFFF);
    rd_chk("R5 undef 0x2C", 8'h2C, 16'h0000);
    rd_chk("R5 undef 0x30", 8'h30, 16'h0000);
    rd_chk("R5 undef 0x01", 8'h01, 16'h0000);
    rd_chk("R5 mode untouched", 8'h00, 16'h005A);
    rd_chk("R5 dir untouched", 8'h20, 16'h0000);
  endtask

  task automatic t_gpio_basic;
    wr(8'h20, 32'h0000_00FF);
    chk("R6 dir eval chg", cap_chg, 16'h0000);
    rd_chk("R6 dir readback", 8'h20, 16'h00FF);
    wr(8'h24, 32'h0000_0F0F);
    chk("R7 lvl gpio", cap_gpio, 16'h000F);
    chk("R8 lvl chg pulse", cap_chg, 16'h000F);
    @(negedge clk_i);
    chk("R8 pulse one cycle", gpio_chg_o, 16'h0000);
    rd_chk("R7 lvl masked store", 8'h24, 16'h000F);
    wr(8'h20, 32'h0000_000C);
    chk("R6 narrow gpio", cap_gpio, 16'h000C);
    chk("R8 narrow chg", cap_chg, 16'h0003);
    rd_chk("R7 lvl kept under narrow dir", 8'h24, 16'h000F);
    wr(8'h20, 32'h0000_FFFF);
    chk("R6 widen gpio", cap_gpio, 16'h000F);
    chk("R8 widen chg", cap_chg, 16'h0003);
  endtask

  task automatic t_ext;
    ext(5'd20, 1'b1);
    rd_chk("R9 line 20 ignored", 8'h24, 16'h000F);
    ext(5'd16, 1'b1);
    rd_chk("R9 line 16 ignored", 8'h24, 16'h000F);
    ext(5'd9, 1'b1);
    chk("R9 no eval gpio", cap_gpio, 16'h000F);
    chk("R9 no eval chg", cap_chg, 16'h0000);
    rd_chk("R9 ext set stored", 8'h24, 16'h020F);
    wr(8'h20, 32'h0000_FFFF);
    chk("R8 same dir eval gpio", cap_gpio, 16'h020F);
    chk("R8 same dir eval chg", cap_chg, 16'h0200);
    ext(5'd0, 1'b0);
    rd_chk("R9 ext clear stored", 8'h24, 16'h020E);
    chk("R9 ext clear no eval", gpio_o, 16'h020F);
  endtask

  task automatic t_collide;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 8'h24; wr_data_i = 32'h0000_1234;
    ext_vld_i = 1'b1; ext_line_i = 5'd15; ext_level_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; ext_vld_i = 1'b0;
    chk("R10 collide gpio", gpio_o, 16'h1234);
    chk("R10 collide chg", gpio_chg_o, 16'h103B);
    rd_chk("R10 collide stored", 8'h24, 16'h1234);
    wr(8'h20, 32'h0000_00F0);
    chk("R8 dir cut chg", cap_chg, 16'h1204);
    wr(8'h24, 32'h0000_FFFF);
    rd_chk("R7 masked by old dir", 8'h24, 16'h00F0);
    chk("R7 gpio after masked lvl", cap_gpio, 16'h00F0);
    chk("R8 chg after masked lvl", cap_chg, 16'h00C0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_plain;
    t_status;
    t_power;
    t_undef;
    t_gpio_basic;
    t_ext;
    t_collide;
    repeat (2) @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule